// File: doc/BRIEF.md
# Microcoded Multicycle Sequencer

This block drives a multicycle 32-bit load/store datapath from a small on-chip microprogram instead of a hand-drawn state machine. A four-bit microaddress register selects one word of a combinational control store. Each word is a set of coded fields: ALU operation, first and second operand source, register-file destination, memory access, instruction-register load, PC update and next-address policy. A decoder turns these fields into the individual datapath control lines.

The next-address policy has three choices. It can step to the following word, return to the common fetch word at address 0, or jump through a dispatch table indexed by the 6-bit opcode. Every instruction starts with a fetch word and a decode word, then runs a short routine of its own. The routines cover a load, a store, a register-register ALU operation, an OR with an immediate, and a branch on equal. An opcode with no dispatch entry raises `illegal_op` and sends control back to fetch.

Top module: `mpc_control_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the microaddress becomes 0. After that edge the outputs show the fetch word.
- R2: The fetch word asserts the following, with every other enable low:
  - `mem_re=1`, `mem_addr_sel=0` (address from PC), `ir_we=1`, `pc_we=1` and `pc_src_sel=0`.
  - `op_a_sel=0` (PC), `op_b_sel=3'b001` (constant 4) and `alu_ctl=2'b00` (add).
  
  The next word is the decode word, which drives `alu_ctl=00`, `op_a_sel=0` and `op_b_sel=3'b011` (sign-extended offset shifted left by 2), with every enable low.
- R3: After the decode word, the opcode selects the routine: 35 load, 43 store, 0 register-register, 13 OR-immediate, 4 branch-on-equal.
- R4: The load routine runs three words, then fetch:
  - address add with `op_a_sel=1` (rs) and `op_b_sel=3'b010` (sign-extended offset);
  - memory read with `mem_re=1` and `mem_addr_sel=1` (ALU result);
  - register write with `rf_we=1`, `rf_wdata_sel=1` (memory data) and `rf_waddr_sel=0` (rt).
- R5: The store routine runs two words, then fetch: the same address add as the load, then `mem_we=1` with `mem_addr_sel=1`. `mem_re` and `mem_we` are never both high.
- R6: The register-register routine runs two words, then fetch: `alu_ctl=2'b10` (function code) with `op_a_sel=1` and `op_b_sel=3'b000` (rt), then `rf_we=1` with `rf_waddr_sel=1` (rd) and `rf_wdata_sel=0`.
- R7: The OR-immediate routine runs two words, then fetch: `alu_ctl=2'b11` with `op_a_sel=1` and `op_b_sel=3'b100` (zero-extended immediate), then `rf_we=1` with `rf_waddr_sel=0`.
- R8: The branch routine is one word, then fetch: `alu_ctl=2'b01` (subtract), `op_a_sel=1`, `op_b_sel=3'b000`, `pc_we_cond=1` and `pc_src_sel=1`. In every word, `pc_en` equals `pc_we OR (pc_we_cond AND zero)`.
- R9: In the decode word, an opcode outside the five listed drives `illegal_op=1`, and the next word is fetch.
- R10: Outside the decode word, the opcode has no effect. `illegal_op` stays 0, and the routine in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| op_a_sel | output | 1 | ALU first operand: 0 PC, 1 rs |
| op_b_sel | output | 3 | ALU second operand select |
| alu_ctl | output | 2 | ALU operation code |
| rf_we | output | 1 | Register file write enable |
| rf_wdata_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| rf_waddr_sel | output | 1 | Register write index: 0 rt, 1 rd |
| mem_re | output | 1 | Memory read |
| mem_we | output | 1 | Memory write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write if zero |
| pc_src_sel | output | 1 | PC source: 0 ALU, 1 ALU result register |
| pc_en | output | 1 | Combined PC write enable |
| illegal_op | output | 1 | Undispatchable opcode in the decode word |

## Verification
The embedded assertions check several properties on every cycle:
- reset lands on fetch, and a sequential step adds one to the microaddress;
- an illegal opcode leads to fetch and is flagged only in a dispatch word;
- the memory read and write enables are exclusive;
- an instruction load comes only with a PC-addressed read;
- `pc_en` never rises without a PC write request, and the `zero` flag alone cannot cause it.

The exact control values in each routine word, and the routine chosen for each legal opcode, can only be shown by the bench's scenarios. So can the fact that the opcode is ignored mid-routine and that a reset taken mid-routine recovers. The bench compares all outputs against its own per-cycle model for these.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int UADDR_W = 4;
    localparam int OPC_W   = 6;

    typedef logic [UADDR_W-1:0] uaddr_t;
    typedef logic [OPC_W-1:0]   opc_t;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNCT = 2'b10, ALU_OR = 2'b11
    } alu_op_e;

    typedef enum logic { SRCA_PC = 1'b0, SRCA_RS = 1'b1 } src_a_e;

    typedef enum logic [2:0] {
        SRCB_RT = 3'b000, SRCB_FOUR = 3'b001, SRCB_SEXT = 3'b010,
        SRCB_SEXT_SH2 = 3'b011, SRCB_ZEXT = 3'b100
    } src_b_e;

    typedef enum logic [1:0] { DST_NONE, DST_RD_ALU, DST_RT_ALU, DST_RT_MEM } dest_e;
    typedef enum logic [1:0] { MEM_NONE, MEM_RD_PC, MEM_RD_ALU, MEM_WR_ALU } mem_e;
    typedef enum logic [1:0] { PCW_NONE, PCW_ALU, PCW_COND } pcw_e;
    typedef enum logic [1:0] { SEQ_FETCH = 2'b00, SEQ_DISPATCH = 2'b01, SEQ_NEXT = 2'b11 } seq_e;

    typedef struct packed {
        alu_op_e alu;
        src_a_e  src1;
        src_b_e  src2;
        dest_e   dest;
        mem_e    mem;
        logic    ir_load;
        pcw_e    pcw;
        seq_e    seq;
    } uinstr_t;

    typedef struct packed {
        logic       op_a_sel;
        logic [2:0] op_b_sel;
        logic [1:0] alu_ctl;
        logic       rf_we;
        logic       rf_wdata_sel;
        logic       rf_waddr_sel;
        logic       mem_re;
        logic       mem_we;
        logic       mem_addr_sel;
        logic       ir_we;
        logic       pc_we;
        logic       pc_we_cond;
        logic       pc_src_sel;
    } ctrl_t;

    localparam uaddr_t UA_FETCH  = 4'd0;
    localparam uaddr_t UA_DECODE = 4'd1;
    localparam uaddr_t UA_LOAD   = 4'd2;
    localparam uaddr_t UA_STORE  = 4'd5;
    localparam uaddr_t UA_RTYPE  = 4'd7;
    localparam uaddr_t UA_ORI    = 4'd9;
    localparam uaddr_t UA_BRANCH = 4'd11;

    localparam opc_t OPC_RTYPE  = 6'd0;
    localparam opc_t OPC_BRANCH = 6'd4;
    localparam opc_t OPC_ORI    = 6'd13;
    localparam opc_t OPC_LOAD   = 6'd35;
    localparam opc_t OPC_STORE  = 6'd43;

    function automatic uinstr_t mk(alu_op_e a, src_a_e s1, src_b_e s2, dest_e d,
                                   mem_e m, logic ir, pcw_e p, seq_e s);
        uinstr_t u;
        u.alu = a; u.src1 = s1; u.src2 = s2; u.dest = d;
        u.mem = m; u.ir_load = ir; u.pcw = p; u.seq = s;
        return u;
    endfunction

endpackage

// File: rtl/mpc_store.sv
module mpc_store
    import mpc_pkg::*;
(
    input  uaddr_t  upc,
    output uinstr_t word
);
    always_comb begin
        unique case (upc)
            4'd0:    word = mk(ALU_ADD,   SRCA_PC, SRCB_FOUR,     DST_NONE,   MEM_RD_PC,  1'b1, PCW_ALU,  SEQ_NEXT);
            4'd1:    word = mk(ALU_ADD,   SRCA_PC, SRCB_SEXT_SH2, DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_DISPATCH);
            4'd2:    word = mk(ALU_ADD,   SRCA_RS, SRCB_SEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd3:    word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_NONE,   MEM_RD_ALU, 1'b0, PCW_NONE, SEQ_NEXT);
            4'd4:    word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_RT_MEM, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd5:    word = mk(ALU_ADD,   SRCA_RS, SRCB_SEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd6:    word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_NONE,   MEM_WR_ALU, 1'b0, PCW_NONE, SEQ_FETCH);
            4'd7:    word = mk(ALU_FUNCT, SRCA_RS, SRCB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd8:    word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_RD_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd9:    word = mk(ALU_OR,    SRCA_RS, SRCB_ZEXT,     DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_NEXT);
            4'd10:   word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_RT_ALU, MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
            4'd11:   word = mk(ALU_SUB,   SRCA_RS, SRCB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_COND, SEQ_FETCH);
            default: word = mk(ALU_ADD,   SRCA_PC, SRCB_RT,       DST_NONE,   MEM_NONE,   1'b0, PCW_NONE, SEQ_FETCH);
        endcase
    end
endmodule

// File: rtl/mpc_dispatch.sv
module mpc_dispatch
    import mpc_pkg::*;
(
    input  opc_t   opcode,
    output uaddr_t target,
    output logic   hit
);
    always_comb begin
        hit    = 1'b1;
        target = UA_FETCH;
        unique case (opcode)
            OPC_LOAD:   target = UA_LOAD;
            OPC_STORE:  target = UA_STORE;
            OPC_RTYPE:  target = UA_RTYPE;
            OPC_ORI:    target = UA_ORI;
            OPC_BRANCH: target = UA_BRANCH;
            default:    hit    = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpc_sequencer.sv
module mpc_sequencer
    import mpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  seq_e   seq,
    input  uaddr_t disp_target,
    input  logic   disp_hit,
    output uaddr_t upc
);
    uaddr_t upc_nxt;

    always_comb begin
        unique case (seq)
            SEQ_NEXT:     upc_nxt = upc + uaddr_t'(1);
            SEQ_DISPATCH: upc_nxt = disp_hit ? disp_target : UA_FETCH;
            default:      upc_nxt = UA_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) upc <= UA_FETCH;
        else     upc <= upc_nxt;
    end

    assert_reset_fetch_R1: assert property (@(posedge clk) rst |=> upc == UA_FETCH);

    assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
        (seq == SEQ_NEXT) |=> upc == $past(upc) + uaddr_t'(1));

    assert_illegal_to_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        (seq == SEQ_DISPATCH && !disp_hit) |=> upc == UA_FETCH);
endmodule

// File: rtl/mpc_decode.sv
module mpc_decode
    import mpc_pkg::*;
(
    input  uinstr_t word,
    input  logic    zero,
    output ctrl_t   ctl,
    output logic    pc_en
);
    always_comb begin
        ctl.op_a_sel     = (word.src1 == SRCA_RS);
        ctl.op_b_sel     = word.src2;
        ctl.alu_ctl      = word.alu;
        ctl.rf_we        = (word.dest != DST_NONE);
        ctl.rf_wdata_sel = (word.dest == DST_RT_MEM);
        ctl.rf_waddr_sel = (word.dest == DST_RD_ALU);
        ctl.mem_re       = (word.mem == MEM_RD_PC) || (word.mem == MEM_RD_ALU);
        ctl.mem_we       = (word.mem == MEM_WR_ALU);
        ctl.mem_addr_sel = (word.mem == MEM_RD_ALU) || (word.mem == MEM_WR_ALU);
        ctl.ir_we        = word.ir_load;
        ctl.pc_we        = (word.pcw == PCW_ALU);
        ctl.pc_we_cond   = (word.pcw == PCW_COND);
        ctl.pc_src_sel   = (word.pcw == PCW_COND);
        pc_en            = ctl.pc_we | (ctl.pc_we_cond & zero);
    end

    always_comb begin
        assert_mem_excl_R5: assert ($onehot0({ctl.mem_re, ctl.mem_we}));
    end
endmodule

// File: rtl/mpc_control_unit.sv
module mpc_control_unit
    import mpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic       zero,
    output logic       op_a_sel,
    output logic [2:0] op_b_sel,
    output logic [1:0] alu_ctl,
    output logic       rf_we,
    output logic       rf_wdata_sel,
    output logic       rf_waddr_sel,
    output logic       mem_re,
    output logic       mem_we,
    output logic       mem_addr_sel,
    output logic       ir_we,
    output logic       pc_we,
    output logic       pc_we_cond,
    output logic       pc_src_sel,
    output logic       pc_en,
    output logic       illegal_op
);
    uaddr_t  upc;
    uinstr_t word;
    uaddr_t  disp_target;
    logic    disp_hit;
    ctrl_t   ctl;

    mpc_store u_store (.upc(upc), .word(word));

    mpc_dispatch u_dispatch (.opcode(opcode), .target(disp_target), .hit(disp_hit));

    mpc_sequencer u_seq (
        .clk(clk), .rst(rst), .seq(word.seq),
        .disp_target(disp_target), .disp_hit(disp_hit), .upc(upc)
    );

    mpc_decode u_decode (.word(word), .zero(zero), .ctl(ctl), .pc_en(pc_en));

    assign op_a_sel     = ctl.op_a_sel;
    assign op_b_sel     = ctl.op_b_sel;
    assign alu_ctl      = ctl.alu_ctl;
    assign rf_we        = ctl.rf_we;
    assign rf_wdata_sel = ctl.rf_wdata_sel;
    assign rf_waddr_sel = ctl.rf_waddr_sel;
    assign mem_re       = ctl.mem_re;
    assign mem_we       = ctl.mem_we;
    assign mem_addr_sel = ctl.mem_addr_sel;
    assign ir_we        = ctl.ir_we;
    assign pc_we        = ctl.pc_we;
    assign pc_we_cond   = ctl.pc_we_cond;
    assign pc_src_sel   = ctl.pc_src_sel;
    assign illegal_op   = (word.seq == SEQ_DISPATCH) && !disp_hit;

    assert_pc_en_source_R8: assert property (@(posedge clk) disable iff (rst)
        pc_en |-> (pc_we || (pc_we_cond && zero)));

    assert_zero_alone_R8: assert property (@(posedge clk) disable iff (rst)
        (!pc_we && !pc_we_cond) |-> !pc_en);

    assert_ir_load_pc_read_R2: assert property (@(posedge clk) disable iff (rst)
        ir_we |-> (mem_re && !mem_addr_sel));

    assert_illegal_only_dispatch_R10: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (word.seq == SEQ_DISPATCH));
endmodule

// File: tb/test_mpc_control_unit.sv
module test_mpc_control_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       zero = 1'b0;
    logic       op_a_sel, rf_we, rf_wdata_sel, rf_waddr_sel, mem_re, mem_we;
    logic       mem_addr_sel, ir_we, pc_we, pc_we_cond, pc_src_sel, pc_en, illegal_op;
    logic [2:0] op_b_sel;
    logic [1:0] alu_ctl;

    int checks = 0;
    int errors = 0;
    int m_state = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mpc_control_unit i_mpc_control_unit (
        .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
        .op_a_sel(op_a_sel), .op_b_sel(op_b_sel), .alu_ctl(alu_ctl),
        .rf_we(rf_we), .rf_wdata_sel(rf_wdata_sel), .rf_waddr_sel(rf_waddr_sel),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr_sel(mem_addr_sel),
        .ir_we(ir_we), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .pc_src_sel(pc_src_sel), .pc_en(pc_en), .illegal_op(illegal_op)
    );

    function automatic bit known_opc(input logic [5:0] o);
        return (o == 6'd35) || (o == 6'd43) || (o == 6'd0) || (o == 6'd13) || (o == 6'd4);
    endfunction

    // Reference next-state model, written from the requirements.
    function automatic int model_next(input int s, input logic [5:0] o);
        case (s)
            0: return 1;
            1: begin
                if (o == 6'd35) return 2;
                if (o == 6'd43) return 5;
                if (o == 6'd0)  return 7;
                if (o == 6'd13) return 9;
                if (o == 6'd4)  return 11;
                return 0;
            end
            2, 3, 5, 7, 9: return s + 1;
            default: return 0;
        endcase
    endfunction

    // Order: a_sel, rf_we, wdata, waddr, mem_re, mem_we, addr_sel, ir_we, pc_we, pc_cond, pc_src, alu[2], b[3]
    function automatic logic [15:0] ev(input logic a, rw, wd, wa, mr, mw, ms, ir, pw, pc, ps,
                                       input logic [1:0] al, input logic [2:0] b);
        return {a, rw, wd, wa, mr, mw, ms, ir, pw, pc, ps, al, b};
    endfunction

    function automatic logic [15:0] model_out(input int s);
        case (s)
            0:  return ev(0,0,0,0,1,0,0,1,1,0,0,2'b00,3'b001);
            1:  return ev(0,0,0,0,0,0,0,0,0,0,0,2'b00,3'b011);
            2:  return ev(1,0,0,0,0,0,0,0,0,0,0,2'b00,3'b010);
            3:  return ev(0,0,0,0,1,0,1,0,0,0,0,2'b00,3'b000);
            4:  return ev(0,1,1,0,0,0,0,0,0,0,0,2'b00,3'b000);
            5:  return ev(1,0,0,0,0,0,0,0,0,0,0,2'b00,3'b010);
            6:  return ev(0,0,0,0,0,1,1,0,0,0,0,2'b00,3'b000);
            7:  return ev(1,0,0,0,0,0,0,0,0,0,0,2'b10,3'b000);
            8:  return ev(0,1,0,1,0,0,0,0,0,0,0,2'b00,3'b000);
            9:  return ev(1,0,0,0,0,0,0,0,0,0,0,2'b11,3'b100);
            10: return ev(0,1,0,0,0,0,0,0,0,0,0,2'b00,3'b000);
            11: return ev(1,0,0,0,0,0,0,0,0,1,1,2'b01,3'b000);
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) m_state <= 0;
        else     m_state <= model_next(m_state, opcode);
    end

    task automatic compare(input string req);
        logic [15:0] act_v, exp_v;
        logic exp_en, exp_ill;
        act_v = {op_a_sel, rf_we, rf_wdata_sel, rf_waddr_sel, mem_re, mem_we, mem_addr_sel,
                 ir_we, pc_we, pc_we_cond, pc_src_sel, alu_ctl, op_b_sel};
        exp_v = model_out(m_state);
        exp_en = exp_v[7] | (exp_v[6] & zero);
        exp_ill = (m_state == 1) && !known_opc(opcode);
        checks++;
        if (act_v !== exp_v || pc_en !== exp_en || illegal_op !== exp_ill) begin
            errors++;
            $display("FAIL %s word %0d: actual ctl=%b pc_en=%b illegal=%b expected ctl=%b pc_en=%b illegal=%b",
                     req, m_state, act_v, pc_en, illegal_op, exp_v, exp_en, exp_ill);
        end
    endtask

    task automatic step(input logic [5:0] o, input logic z, input string req);
        @(negedge clk);
        opcode = o;
        zero = z;
        #1;
        compare(req);
    endtask

    // Fetch, decode with opc, then the routine with a scrambled opcode (R10).
    task automatic run_instr(input logic [5:0] o, input logic z, input string req);
        step(o, z, "R2");
        for (int k = 0; k < 6; k++) begin
            step((k == 0) ? o : (o ^ 6'h2A), z, (k == 0) ? "R3" : req);
            if (model_next(m_state, opcode) == 0) break;
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        step(6'd35, 1'b1, "R1");
        rst = 1'b0;
        run_instr(6'd35, 1'b0, "R4");
        run_instr(6'd43, 1'b1, "R5");
        run_instr(6'd0,  1'b1, "R6");
        run_instr(6'd13, 1'b0, "R7");
        run_instr(6'd4,  1'b1, "R8");
        run_instr(6'd4,  1'b0, "R8");
        run_instr(6'd63, 1'b0, "R9");
        run_instr(6'd5,  1'b1, "R9");
        // R10: opcode swept during fetch and mid-routine.
        step(6'd63, 1'b0, "R10");
        step(6'd0,  1'b0, "R3");
        step(6'd63, 1'b0, "R10");
        step(6'd35, 1'b1, "R10");
        // R1: reset taken in the middle of a load routine.
        run_instr(6'd35, 1'b0, "R4");
        step(6'd35, 1'b0, "R2");
        step(6'd35, 1'b0, "R3");
        step(6'd35, 1'b0, "R4");
        rst = 1'b1;
        step(6'd35, 1'b0, "R1");
        rst = 1'b0;
        step(6'd35, 1'b0, "R1");
        run_instr(6'd43, 1'b0, "R5");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(4 * 20000);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule